// File: doc/BRIEF.md
# Programmable Interrupt Timer

This block is a down-counting timer for a local interrupt controller. Software loads a 32-bit start value, picks a clock divider and sets up a timer entry that carries an interrupt vector, a mask bit and a mode bit. The counter runs from the bus clock through a prescaler. When the count runs out, the timer records one expiry in a small pending counter. While the controller is enabled and the entry is unmasked, it raises an interrupt request that carries the entry's vector.

In one-shot mode the counter stops at zero. In periodic mode it reloads the start value and keeps running. Each accepted delivery (`irq_ack` while `irq_req` is high) removes one pending expiry. All registers are reached through one 32-bit port: writes take effect on the clock edge and reads are combinational. The register addresses are 0 for control (bit 0 is the software enable), 1 for the timer entry, 2 for the start count, 3 for the current count (read only) and 4 for the divider. Any other address reads zero.

Top module: `irq_timer`

## Requirements
- R1: After reset the control register reads 0, the timer entry reads 0x0001_0000 (masked), the start count, current count and divider all read 0, and `irq_req` and `expired` are low.
- R2: The divider index is {divider bit 3, divider bits 1:0}. The divisor is 1 << ((index + 1) mod 8), so index 7 gives 1 and indexes 0 to 6 give 2 to 128. After a start-count write of N, `expired` rises exactly N × divisor cycles after the write edge.
- R3: The divider register stores bits 3:0 of the written word and reads them back with the upper bits zero.
- R4: A start-count write cancels the running count, clears all pending expiries, resets the prescaler and restarts counting from the new value.
- R5: A start count of zero leaves the timer stopped: the current count reads 0 and no expiry occurs.
- R6: The current count equals N minus the number of whole divisor periods elapsed since the start-count write, and it never exceeds the start count.
- R7: With entry bit 17 clear (one-shot), the timer expires once and the current count then stays at 0.
- R8: With entry bit 17 set (periodic), the count reloads from the start value on each expiry, and expiries repeat every N × divisor cycles.
- R9: `irq_req` is high only while the software enable is 1, entry bit 16 (mask) is 0 and at least one expiry is pending. `irq_vector` equals entry bits 7:0.
- R10: Each cycle with `irq_ack` and `irq_req` both high removes one pending expiry. The pending counter saturates at its maximum.
- R11: Writing 0 to control bit 0 sets entry bit 16 and clears all pending expiries. While disabled, any entry write is stored with bit 16 set. Enabling again does not unmask the entry.
- R12: An entry write keeps only bits 7:0 (vector), bit 12 (delivery status), bit 16 (mask) and bit 17 (periodic). All other bits read 0.
- R13: `expired` is high for one cycle per expiry. In one-shot mode it is low in the cycle after an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_ack | input | 1 | Delivery accepted for the current request |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector carried by the request |
| expired | output | 1 | One-cycle expiry pulse |

## Verification
The assertions check on every cycle that the current count never exceeds the start count, that a request appears only when enabled, unmasked and pending, that disabling masks the entry and empties the pending counter, that a start-count write restarts the count and clears pending, and that an acknowledged request drops the pending count by one. Exact expiry timing for each divider code, the read-back of the remaining count part-way through a run, periodic reloads and the field masking of entry writes are shown only by the bench's scenarios. The bench checks these against divisor and count values it computes itself.

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        irq_ack,
  output logic        irq_req,
  output logic [7:0]  irq_vector,
  output logic        expired
);
  localparam logic [2:0]  A_CTRL = 3'd0, A_ENTRY = 3'd1, A_INIT = 3'd2, A_CUR = 3'd3, A_DIV = 3'd4;
  localparam logic [31:0] ENTRY_KEEP = 32'h0003_10FF;
  localparam int          MASK_B = 16;
  localparam int          PER_B  = 17;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              sw_en;
  logic [31:0]       entry;
  logic [CNT_W-1:0]  init_cnt, cur;
  logic [3:0]        div_cfg;
  logic [7:0]        presc;
  logic [PEND_W-1:0] pending;

  logic [2:0] div_shift;
  logic [7:0] div_last;
  logic       running, tick, last_tick, take;

  assign div_shift  = {div_cfg[3], div_cfg[1:0]} + 3'd1;
  assign div_last   = (8'd1 << div_shift) - 8'd1;
  assign running    = (cur != '0);
  assign tick       = running && (presc >= div_last);
  assign last_tick  = tick && (cur == CNT_W'(1));
  assign irq_req    = sw_en && !entry[MASK_B] && (pending != '0);
  assign irq_vector = entry[7:0];
  assign take       = irq_ack && irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en    <= 1'b0;
      entry    <= 32'h1 << MASK_B;
      init_cnt <= '0;
      cur      <= '0;
      div_cfg  <= '0;
      presc    <= '0;
      pending  <= '0;
      expired  <= 1'b0;
    end else begin
      if (running) presc <= tick ? 8'd0 : presc + 8'd1;
      if (tick) cur <= last_tick ? (entry[PER_B] ? init_cnt : '0) : cur - CNT_W'(1);
      expired <= last_tick;
      if (last_tick && !take && pending != PEND_MAX) pending <= pending + 1'b1;
      else if (take && !last_tick) pending <= pending - 1'b1;

      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            sw_en <= wdata[0];
            if (!wdata[0]) begin
              entry[MASK_B] <= 1'b1;
              pending       <= '0;
            end
          end
          A_ENTRY: entry <= (wdata & ENTRY_KEEP) | (sw_en ? 32'h0 : (32'h1 << MASK_B));
          A_INIT: begin
            init_cnt <= wdata[CNT_W-1:0];
            cur      <= wdata[CNT_W-1:0];
            presc    <= '0;
            pending  <= '0;
            expired  <= 1'b0;
          end
          A_DIV: div_cfg <= wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {31'h0, sw_en};
      A_ENTRY: rdata = entry;
      A_INIT:  rdata = 32'(init_cnt);
      A_CUR:   rdata = 32'(cur);
      A_DIV:   rdata = {28'h0, div_cfg};
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [31:0]       wdata,
  input logic              irq_ack,
  input logic              irq_req,
  input logic              sw_en,
  input logic [31:0]       entry,
  input logic [CNT_W-1:0]  init_cnt,
  input logic [CNT_W-1:0]  cur,
  input logic [PEND_W-1:0] pending,
  input logic              last_tick
);
  AST_CUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cur <= init_cnt); // R6
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> (sw_en && !entry[16] && pending != '0)); // R9
  AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 3'd0 && !wdata[0]) |=> (entry[16] && pending == '0 && !irq_req)); // R11
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 3'd2) |=> (pending == '0 && cur == $past(wdata[CNT_W-1:0]))); // R4
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (irq_ack && irq_req && !last_tick && !wr_en) |=> (pending == $past(pending) - 1'b1)); // R10
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (init_cnt == '0) |-> (cur == '0)); // R5
endmodule

bind irq_timer irq_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_ack(irq_ack), .irq_req(irq_req), .sw_en(sw_en), .entry(entry),
  .init_cnt(init_cnt), .cur(cur), .pending(pending), .last_tick(last_tick)
);

// File: tb/sim_irq_timer.sv
`timescale 1ns/1ps
module sim_irq_timer;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'h0, rdata;
  logic        irq_req, expired;
  logic [7:0]  irq_vector;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] CTRL = 3'd0, ENTRY = 3'd1, INIT = 3'd2, CUR = 3'd3, DIV = 3'd4;

  irq_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .irq_ack(irq_ack), .irq_req(irq_req),
                .irq_vector(irq_vector), .expired(expired));

  always #10 clk = ~clk;

  function automatic int divisor_of(input logic [3:0] code);
    int idx = {code[3], code[1:0]};
    return 1 << ((idx + 1) % 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_expiry(output int cyc);
    cyc = 0;
    while (!expired && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    logic [31:0] v;
    int cyc, n, d, k;
    logic [3:0] code;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(ENTRY, v); check("R1 entry", v, 32'h0001_0000);
    rd(INIT, v);  check("R1 init", v, 0);
    rd(CUR, v);   check("R1 cur", v, 0);
    rd(DIV, v);   check("R1 div", v, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 expired", expired, 0);

    // R2 R6 R7 R13: random divider codes and counts, one-shot
    for (int i = 0; i < 14; i++) begin
      code = 4'($urandom % 16);
      n = 1 + $urandom % 6;
      d = divisor_of(code);
      k = $urandom % (n * d);
      wr(DIV, {28'h0, code});
      wr(ENTRY, 32'h0000_0020);
      wr(INIT, n);
      repeat (k) @(negedge clk);
      rd(CUR, v); check("R6 remaining count", v, n - k / d);
      wait_expiry(cyc);
      check("R2 expiry time", k + cyc, n * d);
      @(negedge clk);
      check("R13 single pulse", expired, 0);
      rd(CUR, v); check("R7 one-shot stays zero", v, 0);
    end
    repeat (20) @(negedge clk);
    check("R7 no second expiry", expired, 0);

    // R8 periodic: N=3, divide code 0 -> 2, interval 6
    wr(DIV, 32'h0);
    wr(ENTRY, 32'h0002_0030);
    wr(INIT, 3);
    wait_expiry(cyc); check("R8 first period", cyc, 6);
    for (int j = 0; j < 2; j++) begin
      @(negedge clk); wait_expiry(cyc);
      check("R8 reload period", cyc + 1, 6);
    end

    // R3 divider field
    wr(DIV, 32'hFFFF_FFFF);
    rd(DIV, v); check("R3 divider readback", v, 32'hF);

    // R12 entry field masking (enabled)
    wr(CTRL, 1);
    wr(ENTRY, 32'hFFFF_FFFF);
    rd(ENTRY, v); check("R12 entry fields", v, 32'h0003_10FF);

    // R10 R9: pending counting with periodic then one-shot, divide-by-1
    wr(DIV, 32'hB);
    wr(ENTRY, 32'h0002_0045);
    wr(INIT, 2);
    repeat (4) @(negedge clk);
    wr(ENTRY, 32'h0000_0045);
    repeat (6) @(negedge clk);
    check("R9 request raised", irq_req, 1);
    check("R9 vector", irq_vector, 8'h45);
    irq_ack = 1'b1;
    repeat (3) @(negedge clk);
    irq_ack = 1'b0;
    check("R10 one pending left", irq_req, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R10 all pending consumed", irq_req, 0);

    // R4 restart clears pending and reloads
    wr(INIT, 1);
    @(negedge clk);
    check("R9 request after expiry", irq_req, 1);
    wr(INIT, 1000);
    check("R4 pending cleared", irq_req, 0);
    repeat (10) @(negedge clk);
    rd(CUR, v); check("R4 count restarted", v, 990);
    wr(INIT, 5);
    wait_expiry(cyc); check("R4 new count timing", cyc, 5);

    // R11 disable masks and clears
    wr(INIT, 1);
    @(negedge clk);
    check("R11 setup request", irq_req, 1);
    wr(CTRL, 0);
    check("R11 request dropped", irq_req, 0);
    rd(ENTRY, v); check("R11 entry masked", v, 32'h0001_0045);
    wr(ENTRY, 32'h0000_0045);
    rd(ENTRY, v); check("R11 write forced masked", v, 32'h0001_0045);
    wr(CTRL, 1);
    rd(ENTRY, v); check("R11 enable keeps mask", v, 32'h0001_0045);
    wr(ENTRY, 32'h0000_0045);
    check("R11 pending was cleared", irq_req, 0);

    // R5 zero start count stops the timer
    wr(INIT, 100);
    repeat (5) @(negedge clk);
    wr(INIT, 0);
    rd(CUR, v); check("R5 current reads zero", v, 0);
    k = 0;
    repeat (50) begin @(negedge clk); if (expired) k++; end
    check("R5 no expiry", k, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule